// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block collects eight interrupt request lines and reports the most urgent one to a processor. Software drives it through two byte addresses: a command address and a data address. The block records the incoming requests in a request register and blocks lines through a mask register. It raises a single interrupt output when an unmasked request is allowed to run. When the processor pulses an acknowledge, the block returns a vector byte and, unless it is in auto-completion mode, records the granted level in an in-service register. Software later clears that level with a specific end-of-interrupt command.

Before it raises any interrupt, the block has to be configured with a short initialization sequence. That sequence sets the vector base, the cascade arrangement and the completion mode. Several of these controllers can be chained. A controller strapped as the master marks the inputs that have a downstream controller attached. When it grants such an input, it drives that level number out on a select bus and leaves the vector to the downstream controller. A controller strapped as a slave answers an acknowledge only when the select bus carries its own identity number.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the block is uninitialized, `irq_out` is low, a data-address read returns 0xFF, and a command-address read returns the request register.
- R2: A command-address write with bit 4 set starts initialization. The next three data-address writes are taken as the vector base, the cascade word and the mode word, in that order. Input n then yields the vector base plus n.
- R3: `irq_out` is high only when the block is initialized and at least one unmasked request is allowed to run under R10.
- R4: When bit 1 of the mode word is set, an acknowledge sets no in-service bit, so no end-of-interrupt command is needed.
- R5: Outside initialization, a data-address write loads the mask register, where bit n set blocks input n. A data-address read returns the mask.
- R6: A command-address write of 0x60 plus level L (0 to 7) clears in-service bit L and leaves the other in-service bits unchanged.
- R7: After a command write of 0x0B, command-address reads return the in-service register. After a command write of 0x0A, they return the request register.
- R8: An acknowledge with no runnable request returns the vector base plus 7 and sets no in-service bit, even when input 7 is masked.
- R9: Starting initialization sets the mask to 0xFF, clears the in-service register and selects the request register for reads. The mask stays at 0xFF after the mode word until software rewrites it.
- R10: Input 0 has the highest priority. A request on level n can run only when no in-service bit at level n or any higher-priority level is set.
- R11: A master that grants an input whose bit is set in the cascade word drives `cas_hit_out` high with `cas_sel_out` equal to that level during the acknowledge, and returns no vector. A slave answers an acknowledge only when `cas_hit_in` is high and `cas_sel_in` equals the low three bits of its cascade word.
- R12: If bit 3 of the first initialization word is clear, request bits follow the sampled inputs (level mode). If it is set, a request bit is set by a rising input and cleared when that level is granted (edge mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the command address, 1 selects the data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address in `bus_addr` |
| irq_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge pulse |
| vec_valid | output | 1 | Vector returned, one cycle after the acknowledge |
| vec_out | output | 8 | Returned vector |
| slave_mode | input | 1 | Strap: 1 makes this controller a slave |
| cas_sel_in | input | 3 | Select bus from the master (slave use) |
| cas_hit_in | input | 1 | Select bus valid (slave use) |
| cas_sel_out | output | 3 | Level forwarded to a slave (master use) |
| cas_hit_out | output | 1 | Select bus valid (master use) |

## Verification
Most internal faults in this block first show up as a wrong in-service register. A stuck or wrongly cleared in-service bit shows up right away in a command-address read after 0x0B. It also changes `irq_out` on the next cycle, because it blocks or releases lower-priority levels. A wrong request register shows up one cycle after an input change, both on `irq_out` and in a 0x0A readback. A fault in the initialization word order or in the vector arithmetic appears as a wrong `vec_out` one cycle after the first acknowledge.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int LINES  = 8;
    localparam int LVL_W  = $clog2(LINES);
    localparam int DATA_W = 8;

    typedef logic [LINES-1:0]  line_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_st_e;

    typedef struct packed {
        logic  ready;
        logic  edge_mode;
        logic  aeoi;
        logic  rd_isr;
        byte_t base;
        byte_t casw;
        line_t mask;
    } cfg_t;

    localparam byte_t       CMD_RD_IRR = 8'h0A;
    localparam byte_t       CMD_RD_ISR = 8'h0B;
    localparam logic [4:0]  EOI_OP     = 5'b01100;
    localparam int          MODE_AEOI  = 1;
    localparam int          ICW1_FLAG  = 4;
    localparam int          ICW1_EDGE  = 3;

    // lowest set index wins (index 0 is highest priority)
    function automatic lvl_t first_set(line_t v);
        lvl_t r = '0;
        for (int i = LINES-1; i >= 0; i--)
            if (v[i]) r = lvl_t'(i);
        return r;
    endfunction

    // bit n set when no in-service bit at n or above in priority
    function automatic line_t allow_mask(line_t isr);
        line_t r;
        logic  busy = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            busy = busy | isr[i];
            r[i] = ~busy;
        end
        return r;
    endfunction
endpackage

// File: rtl/pic8_regs.sv
module pic8_regs
    import pic8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  addr,
    input  byte_t wdata,
    output cfg_t  cfg,
    output logic  init_stb,
    output logic  eoi_stb,
    output lvl_t  eoi_lvl
);
    init_st_e st;

    assign init_stb = wr && !addr && wdata[ICW1_FLAG];
    assign eoi_stb  = wr && !addr && cfg.ready && (wdata[DATA_W-1:LVL_W] == EOI_OP);
    assign eoi_lvl  = wdata[LVL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RUN;
            cfg.ready <= 1'b0;
            cfg.edge_mode <= 1'b0;
            cfg.aeoi  <= 1'b0;
            cfg.rd_isr <= 1'b0;
            cfg.base  <= '0;
            cfg.casw  <= '0;
            cfg.mask  <= '1;
        end else if (wr) begin
            if (init_stb) begin
                st            <= ST_BASE;
                cfg.ready     <= 1'b0;
                cfg.edge_mode <= wdata[ICW1_EDGE];
                cfg.mask      <= '1;
                cfg.rd_isr    <= 1'b0;
            end else if (!addr) begin
                if (wdata == CMD_RD_IRR) cfg.rd_isr <= 1'b0;
                if (wdata == CMD_RD_ISR) cfg.rd_isr <= 1'b1;
            end else begin
                unique case (st)
                    ST_BASE: begin cfg.base <= wdata; st <= ST_CASC; end
                    ST_CASC: begin cfg.casw <= wdata; st <= ST_MODE; end
                    ST_MODE: begin
                        cfg.aeoi  <= wdata[MODE_AEOI];
                        cfg.ready <= 1'b1;
                        st        <= ST_RUN;
                    end
                    default: cfg.mask <= wdata[LINES-1:0];
                endcase
            end
        end
    end

    // R9: starting initialization leaves everything masked and not ready
    a_r9_mask_full: assert property (@(posedge clk) disable iff (rst)
        init_stb |=> (cfg.mask == '1) && !cfg.ready && !cfg.rd_isr);
    // R2: the third data write after the start word completes initialization
    a_r2_ready_after_mode: assert property (@(posedge clk) disable iff (rst)
        (wr && addr && st == ST_MODE) |=> cfg.ready);
endmodule

// File: rtl/pic8_arb.sv
module pic8_arb
    import pic8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  line_t irq_in,
    input  logic  ack,
    input  logic  slave_mode,
    input  lvl_t  cas_sel_in,
    input  logic  cas_hit_in,
    input  logic  init_stb,
    input  logic  eoi_stb,
    input  lvl_t  eoi_lvl,
    output line_t irr,
    output line_t isr,
    output logic  irq_out,
    output logic  vec_valid,
    output byte_t vec_out,
    output lvl_t  cas_sel_out,
    output logic  cas_hit_out
);
    line_t prev, pend, win_oh, eoi_oh;
    lvl_t  win;
    logic  any, selected, take, grant, to_slave;

    always_comb begin
        pend     = irr & ~cfg.mask & allow_mask(isr);
        any      = cfg.ready && (|pend);
        win      = first_set(pend);
        win_oh   = line_t'(1) << win;
        eoi_oh   = eoi_stb ? (line_t'(1) << eoi_lvl) : '0;
        selected = slave_mode ? (cas_hit_in && cas_sel_in == cfg.casw[LVL_W-1:0]) : 1'b1;
        take     = ack && cfg.ready && selected;
        grant    = take && any;
        to_slave = grant && !slave_mode && cfg.casw[win];
    end

    assign irq_out     = any;
    assign cas_hit_out = to_slave;
    assign cas_sel_out = to_slave ? win : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= '0;
            irr       <= '0;
            isr       <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            prev <= irq_in;
            if (cfg.edge_mode)
                irr <= (irr & ~(grant ? win_oh : '0)) | (irq_in & ~prev);
            else
                irr <= irq_in;
            if (init_stb)
                isr <= '0;
            else
                isr <= (isr & ~eoi_oh) | ((grant && !cfg.aeoi) ? win_oh : '0);
            vec_valid <= take && !to_slave;
            if (take)
                vec_out <= cfg.base + byte_t'(grant ? win : lvl_t'(LINES-1));
        end
    end

    // R4: auto-completion never leaves an in-service bit behind
    a_r4_aeoi_no_isr: assert property (@(posedge clk) disable iff (rst)
        cfg.aeoi |-> (isr == '0));
    // R6: a specific completion clears its level
    a_r6_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (eoi_stb && !ack) |=> !isr[$past(eoi_lvl)]);
    // R8: a spurious acknowledge leaves the in-service register alone
    a_r8_spurious_no_isr: assert property (@(posedge clk) disable iff (rst)
        (take && !any && !eoi_stb && !init_stb) |=> (isr == $past(isr)));
    // R10: at most one new in-service bit per acknowledge
    a_r10_single_grant: assert property (@(posedge clk) disable iff (rst)
        ack |=> ($countones(isr & ~$past(isr)) <= 1));
    // R11: a returned vector always follows an acknowledge
    a_r11_vec_after_ack: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack));
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] irq_in,
    output logic       irq_out,
    input  logic       int_ack,
    output logic       vec_valid,
    output logic [7:0] vec_out,
    input  logic       slave_mode,
    input  logic [2:0] cas_sel_in,
    input  logic       cas_hit_in,
    output logic [2:0] cas_sel_out,
    output logic       cas_hit_out
);
    cfg_t  cfg;
    logic  init_stb, eoi_stb;
    lvl_t  eoi_lvl;
    line_t irr, isr;

    pic8_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cfg(cfg), .init_stb(init_stb), .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl)
    );

    pic8_arb u_arb (
        .clk(clk), .rst(rst), .cfg(cfg), .irq_in(irq_in), .ack(int_ack),
        .slave_mode(slave_mode), .cas_sel_in(cas_sel_in), .cas_hit_in(cas_hit_in),
        .init_stb(init_stb), .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl),
        .irr(irr), .isr(isr), .irq_out(irq_out), .vec_valid(vec_valid),
        .vec_out(vec_out), .cas_sel_out(cas_sel_out), .cas_hit_out(cas_hit_out)
    );

    always_comb begin
        if (bus_addr) bus_rdata = byte_t'(cfg.mask);
        else          bus_rdata = byte_t'(cfg.rd_isr ? isr : irr);
    end

    // R3: no interrupt before initialization completes
    a_r3_quiet_uninit: assert property (@(posedge clk) disable iff (rst)
        $rose(init_stb) |=> !irq_out);
endmodule

// File: tb/pic8_ctrl_bench.sv
module pic8_ctrl_bench;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] irq_in = '0;
    logic       irq_out, int_ack = 1'b0, vec_valid;
    logic [7:0] vec_out;
    logic       slave_mode = 1'b0;
    logic [2:0] cas_sel_in = '0, cas_sel_out;
    logic       cas_hit_in = 1'b0, cas_hit_out;

    int checks = 0, errors = 0;
    logic done = 1'b0;
    logic       a_hit;
    logic [2:0] a_sel;

    always #(CLK_NS/2) clk = ~clk;

    pic8_ctrl u_pic8_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_out(irq_out), .int_ack(int_ack), .vec_valid(vec_valid),
        .vec_out(vec_out), .slave_mode(slave_mode), .cas_sel_in(cas_sel_in),
        .cas_hit_in(cas_hit_in), .cas_sel_out(cas_sel_out), .cas_hit_out(cas_hit_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        int_ack = 1'b1;
        #1 a_hit = cas_hit_out; a_sel = cas_sel_out;
        @(posedge clk);
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic init(input logic [7:0] w1, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] m);
        wr(1'b0, w1); wr(1'b1, b); wr(1'b1, c); wr(1'b1, m);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq_out", irq_out, 0);
        rd(1'b1, d); chk("R1 mask", d, 8'hFF);
        set_irq(8'h10);
        rd(1'b0, d); chk("R1 irr read", d, 8'h10);
        chk("R3 uninit irq_out", irq_out, 0);
        set_irq(8'h00);
    endtask

    task automatic t_init_mask();
        logic [7:0] d;
        init(8'h11, 8'h20, 8'h04, 8'h00);
        rd(1'b1, d); chk("R9 mask after init", d, 8'hFF);
        set_irq(8'h08);
        chk("R5 masked no irq", irq_out, 0);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R5 mask readback", d, 8'h00);
        chk("R3 irq_out", irq_out, 1);
        ack();
        chk("R2 vec_valid", vec_valid, 1);
        chk("R2 vector", vec_out, 8'h23);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R7 isr read", d, 8'h08);
    endtask

    task automatic t_priority_eoi();
        logic [7:0] d;
        chk("R10 blocked by own isr", irq_out, 0);
        set_irq(8'h28);
        chk("R10 lower blocked", irq_out, 0);
        set_irq(8'h2A);
        chk("R10 higher runs", irq_out, 1);
        ack();
        chk("R10 vector", vec_out, 8'h21);
        rd(1'b0, d); chk("R10 nested isr", d, 8'h0A);
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R6 eoi level 1", d, 8'h08);
        wr(1'b0, 8'h63);
        rd(1'b0, d); chk("R6 eoi level 3", d, 8'h00);
        chk("R10 released", irq_out, 1);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R7 irr read", d, 8'h2A);
        set_irq(8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        wr(1'b1, 8'hFF);
        ack();
        chk("R8 spurious valid", vec_valid, 1);
        chk("R8 spurious vector", vec_out, 8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 no isr", d, 8'h00);
    endtask

    task automatic t_cascade_master();
        logic [7:0] d;
        wr(1'b1, 8'h00);
        set_irq(8'h04);
        ack();
        chk("R11 master hit", a_hit, 1);
        chk("R11 master sel", a_sel, 2);
        chk("R11 no master vector", vec_valid, 0);
        rd(1'b0, d); chk("R11 cascade isr", d, 8'h04);
        wr(1'b0, 8'h62);
        set_irq(8'h00);
    endtask

    task automatic t_edge_aeoi();
        logic [7:0] d;
        init(8'h19, 8'h40, 8'h00, 8'h02);
        rd(1'b0, d); chk("R9 isr cleared", d, 8'h00);
        wr(1'b1, 8'h00);
        set_irq(8'h01);
        chk("R12 edge sets", irq_out, 1);
        ack();
        chk("R4 vector", vec_out, 8'h40);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R4 no isr", d, 8'h00);
        chk("R12 edge cleared on grant", irq_out, 0);
        set_irq(8'h00);
    endtask

    task automatic t_slave();
        logic [7:0] d;
        slave_mode = 1'b1;
        init(8'h11, 8'h70, 8'h03, 8'h00);
        wr(1'b1, 8'h00);
        set_irq(8'h02);
        cas_hit_in = 1'b1; cas_sel_in = 3'd2;
        ack();
        chk("R11 slave ignores other id", vec_valid, 0);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R11 slave isr untouched", d, 8'h00);
        cas_sel_in = 3'd3;
        ack();
        chk("R11 slave answers", vec_valid, 1);
        chk("R11 slave vector", vec_out, 8'h71);
        cas_hit_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_init_mask();
        t_priority_eoi();
        t_spurious();
        t_cascade_master();
        t_edge_aeoi();
        t_slave();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule